// File: doc/BRIEF.md
# Flash portal command controller

This block lets a local processor read, program or erase an attached flash array through a small register portal. Software first stages its settings: a flash byte address, a start offset into a 64-byte local data buffer, and a command word that holds the operation type and a length. It then writes a one to the start register. The engine checks the request in the same cycle. It checks that the portal is idle, that the global enable is set, and that the length is legal for the operation type. If all checks pass, the engine runs the request against a simplified flash backend. Otherwise it refuses the request and records the reason in the status register.

Read and write operations move one byte per backend handshake. The flash address rises by one for each byte. The buffer index rises by one as well and wraps modulo 64. An erase is a single handshake that carries a 2-bit size code. Completion and every error condition are recorded in sticky status bits, and software clears them by writing ones. A done interrupt is raised while the done bit is set and the interrupt enable is on.

Top module: `flash_portal_ctrl`

## Requirements
- R1: After reset, STATUS (offset 6) reads 0, CTRL (offset 0) reads 0, CAPS (offset 1) reads 1, INTEN (offset 7) reads 0, irq is low and be_req is low.
- R2: A start (a write of 1 in bit 0 to offset 5) while CTRL bit 0 is clear sets STATUS bit 0 (done) and bit 2 (disabled error). It issues no backend request.
- R3: The CMD register (offset 4) holds the operation type in bits 1:0 and the length in bits 14:8. Type 0 is read and type 1 is write. For these types, a length outside 1 to 64 sets done and STATUS bit 1 (parameter error), and no request is issued.
- R4: For an erase (type 2), the length field is a size code: 0 = 4 KB, 1 = 32 KB, 2 = 64 KB. The erase is accepted only if the field is at most 2 and the matching CAPS bit is set. CAPS bit 0 always reads 1. Any other erase sets done and the parameter error.
- R5: Type 3 is always refused with done and the parameter error.
- R6: STATUS bit 8 (busy) reads 1 from the cycle after an accepted start. It reads 0 from the same cycle in which done becomes 1.
- R7: A start while busy sets STATUS bit 3 (busy error) only. The running operation continues unchanged, and no second operation starts.
- R8: A write of length L issues L requests with be_op = 1. Request i carries flash address FADDR+i and the byte at buffer[(BADDR+i) mod 64]. Software accesses the buffer at register offsets 64 to 127.
- R9: A read of length L issues L requests with be_op = 0. The be_rdata of request i is stored at buffer[(BADDR+i) mod 64].
- R10: An accepted erase issues exactly one request with be_op = 2, be_addr = FADDR and be_size = the size code.
- R11: be_err on an acknowledged request ends the operation at once. It sets done and STATUS bit 4 (backend error).
- R12: STATUS bits 4:0 clear where ones are written to offset 6. Zero bits leave the status unchanged, and a new event in the same cycle wins.
- R13: irq equals STATUS done AND INTEN bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register / buffer byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| irq | output | 1 | Done interrupt |
| be_req | output | 1 | Backend request, held until acknowledged |
| be_op | output | 2 | Backend operation: 0 read, 1 write, 2 erase |
| be_addr | output | 24 | Flash byte address |
| be_size | output | 2 | Erase size code |
| be_wdata | output | 8 | Byte to program |
| be_ack | input | 1 | Backend acknowledge |
| be_rdata | input | 8 | Byte read from flash, valid with be_ack |
| be_err | input | 1 | Backend error, valid with be_ack |

## Verification
A wrong beat counter or buffer pointer shows up at once on be_addr and be_wdata, or in the buffer contents that software reads back after a read operation. A missing final beat shows up as a busy flag that never clears. A sequencer that does not return to idle cleanly shows up as done and busy being set together, or as a second start being accepted, at the first status read after the operation. Faults in the validation path show up as backend requests that should not exist, or as the wrong error bit, on the same cycle as the start write.

// File: rtl/fpc_pkg.sv
// Shared types and register layout for the flash portal controller.
// Assumes a byte-per-beat backend and a power-of-two local buffer.
package fpc_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_XFER = 1'b1
    } seq_e;

    // Register offsets inside the control window
    localparam int OFF_CTRL   = 0;
    localparam int OFF_CAPS   = 1;
    localparam int OFF_FADDR  = 2;
    localparam int OFF_BADDR  = 3;
    localparam int OFF_CMD    = 4;
    localparam int OFF_START  = 5;
    localparam int OFF_STATUS = 6;
    localparam int OFF_INTEN  = 7;

    // Status bit positions
    localparam int ST_DONE   = 0;
    localparam int ST_EPARAM = 1;
    localparam int ST_EOFF   = 2;
    localparam int ST_EBUSY  = 3;
    localparam int ST_EBACK  = 4;
    localparam int ST_W      = 5;
    localparam int ST_BUSY   = 8;

    // Command word length field position
    localparam int CMD_LEN_LSB = 8;

endpackage

// File: rtl/fpc_check.sv
// Start validation for the flash portal controller.
// Purely combinational: it classifies a start strobe as launched or
// refused. Refusal order: busy first, then disabled, then parameters.
module fpc_check
    import fpc_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int MAX_LEN = 64
) (
    input  logic             go_i,
    input  logic             busy_i,
    input  logic             en_i,
    input  op_e              op_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [2:0]       caps_i,
    output logic             launch_o,
    output logic             rej_busy_o,
    output logic             rej_off_o,
    output logic             rej_param_o
);

    logic       legal;
    logic [3:0] caps_ext;

    // Legality of the staged command for its operation type
    always_comb begin
        caps_ext = {1'b0, caps_i};
        unique case (op_i)
            OP_READ, OP_WRITE: legal = (len_i != '0) && (len_i <= LEN_W'(MAX_LEN));
            OP_ERASE:          legal = ((len_i >> 2) == '0) && caps_ext[len_i[1:0]];
            default:           legal = 1'b0;
        endcase
    end

    // Priority classification of a start strobe
    always_comb begin
        rej_busy_o  = go_i && busy_i;
        rej_off_o   = go_i && !busy_i && !en_i;
        rej_param_o = go_i && !busy_i && en_i && !legal;
        launch_o    = go_i && !busy_i && en_i && legal;
    end

endmodule

// File: rtl/fpc_buf.sv
// Local data buffer for the flash portal controller.
// Two combinational read ports and two write ports. The engine write
// wins a same-index collision. Contents are not reset.
module fpc_buf #(
    parameter int DEPTH = 64,
    parameter int BI_W  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            e_we,
    input  logic [BI_W-1:0] e_idx,
    input  logic [7:0]      e_wdata,
    output logic [7:0]      e_rdata,
    input  logic            s_we,
    input  logic [BI_W-1:0] s_idx,
    input  logic [7:0]      s_wdata,
    output logic [7:0]      s_rdata
);

    logic [7:0] mem [DEPTH];

    // Write ports, engine has priority on the same byte
    always_ff @(posedge clk) begin
        if (s_we && !(e_we && (s_idx == e_idx))) mem[s_idx] <= s_wdata;
        if (e_we) mem[e_idx] <= e_wdata;
    end

    // Read ports
    always_comb begin
        e_rdata = mem[e_idx];
        s_rdata = mem[s_idx];
    end

endmodule

// File: rtl/fpc_seq.sv
// Operation sequencer for the flash portal controller.
// Captures the command on launch, then holds a backend request per
// beat until acknowledged. Reads land in the buffer, writes come from it.
module fpc_seq
    import fpc_pkg::*;
#(
    parameter int FA_W  = 24,
    parameter int BI_W  = 6,
    parameter int LEN_W = BI_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  op_e              op_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [FA_W-1:0]  faddr_i,
    input  logic [BI_W-1:0]  baddr_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic             fin_err_o,
    output logic             be_req,
    output logic [1:0]       be_op,
    output logic [FA_W-1:0]  be_addr,
    output logic [1:0]       be_size,
    output logic [7:0]       be_wdata,
    input  logic             be_ack,
    input  logic [7:0]       be_rdata,
    input  logic             be_err,
    output logic [BI_W-1:0]  buf_idx,
    output logic             buf_we,
    output logic [7:0]       buf_wdata,
    input  logic [7:0]       buf_rdata
);

    seq_e             state_q;
    op_e              op_q;
    logic [LEN_W-1:0] len_q;
    logic [FA_W-1:0]  faddr_q;
    logic [BI_W-1:0]  baddr_q;
    logic [BI_W-1:0]  beat_q;
    logic             xfer;
    logic             last;
    logic             beat_ok;

    // Beat classification and backend outputs
    always_comb begin
        xfer      = (state_q == SQ_XFER);
        last      = (op_q == OP_ERASE) || ({1'b0, beat_q} == (len_q - LEN_W'(1)));
        beat_ok   = xfer && be_ack;
        fin_o     = beat_ok && (be_err || last);
        fin_err_o = beat_ok && be_err;
        busy_o    = xfer;
        be_req    = xfer;
        be_op     = op_q;
        be_addr   = faddr_q + FA_W'(beat_q);
        be_size   = len_q[1:0];
        buf_idx   = baddr_q + beat_q;
        be_wdata  = buf_rdata;
        buf_we    = beat_ok && !be_err && (op_q == OP_READ);
        buf_wdata = be_rdata;
    end

    // State and command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            op_q    <= OP_READ;
            len_q   <= '0;
            faddr_q <= '0;
            baddr_q <= '0;
            beat_q  <= '0;
        end else if (!xfer) begin
            if (launch_i) begin
                state_q <= SQ_XFER;
                op_q    <= op_i;
                len_q   <= len_i;
                faddr_q <= faddr_i;
                baddr_q <= baddr_i;
                beat_q  <= '0;
            end
        end else if (be_ack) begin
            if (be_err || last) state_q <= SQ_IDLE;
            else                beat_q  <= beat_q + BI_W'(1);
        end
    end

    // R8: a pending request keeps its fields until acknowledged
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && !be_ack |=> be_req && $stable(be_addr) && $stable(be_op));

    // R3: no transfer beat beyond the programmed length
    a_r3_beat_bound: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && (be_op != 2'd2) |-> ({1'b0, beat_q} < len_q));

    // R10: an erase is a single handshake
    a_r10_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
        be_req && be_ack && (be_op == 2'd2) |=> !be_req);

endmodule

// File: rtl/fpc_regs.sv
// Register file for the flash portal controller.
// Holds the control, capability, address, command, status and interrupt
// enable registers. Decodes the start strobe and maps the buffer window.
module fpc_regs
    import fpc_pkg::*;
#(
    parameter int FA_W  = 24,
    parameter int DW    = 32,
    parameter int BI_W  = 6,
    parameter int RA_W  = BI_W + 1,
    parameter int LEN_W = BI_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq,
    output logic             en_o,
    output logic [2:0]       caps_o,
    output logic [FA_W-1:0]  faddr_o,
    output logic [BI_W-1:0]  baddr_o,
    output op_e              op_o,
    output logic [LEN_W-1:0] len_o,
    output logic             go_o,
    input  logic             busy_i,
    input  logic             fin_i,
    input  logic             fin_err_i,
    input  logic             rej_busy_i,
    input  logic             rej_off_i,
    input  logic             rej_param_i,
    output logic             sw_buf_we,
    output logic [BI_W-1:0]  sw_buf_idx,
    output logic [7:0]       sw_buf_wdata,
    input  logic [7:0]       sw_buf_rdata
);

    logic            en_q;
    logic [2:1]      caps_q;
    logic [FA_W-1:0] faddr_q;
    logic [BI_W-1:0] baddr_q;
    op_e             op_q;
    logic [LEN_W-1:0] len_q;
    logic            inten_q;
    logic [ST_W-1:0] sts_q;
    logic [ST_W-1:0] sts_nxt;
    logic            win;
    logic [BI_W-1:0] roff;
    logic            wr_sts;
    logic            unused_wdata;

    // Address decode helpers
    always_comb begin
        win    = reg_addr[RA_W-1];
        roff   = reg_addr[BI_W-1:0];
        wr_sts = reg_we && !win && (roff == BI_W'(OFF_STATUS));
        go_o   = reg_we && !win && (roff == BI_W'(OFF_START)) && reg_wdata[0];
    end

    assign unused_wdata = ^reg_wdata;

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            caps_q  <= '0;
            faddr_q <= '0;
            baddr_q <= '0;
            op_q    <= OP_READ;
            len_q   <= '0;
            inten_q <= 1'b0;
        end else if (reg_we && !win) begin
            unique case (roff)
                BI_W'(OFF_CTRL):  en_q    <= reg_wdata[0];
                BI_W'(OFF_CAPS):  caps_q  <= reg_wdata[2:1];
                BI_W'(OFF_FADDR): faddr_q <= reg_wdata[FA_W-1:0];
                BI_W'(OFF_BADDR): baddr_q <= reg_wdata[BI_W-1:0];
                BI_W'(OFF_CMD): begin
                    op_q  <= op_e'(reg_wdata[1:0]);
                    len_q <= reg_wdata[CMD_LEN_LSB +: LEN_W];
                end
                BI_W'(OFF_INTEN): inten_q <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Status next value: write-one-to-clear, then events set
    always_comb begin
        sts_nxt = sts_q;
        if (wr_sts) sts_nxt = sts_nxt & ~reg_wdata[ST_W-1:0];
        if (fin_i || rej_off_i || rej_param_i) sts_nxt[ST_DONE] = 1'b1;
        if (rej_param_i) sts_nxt[ST_EPARAM] = 1'b1;
        if (rej_off_i)   sts_nxt[ST_EOFF]   = 1'b1;
        if (rej_busy_i)  sts_nxt[ST_EBUSY]  = 1'b1;
        if (fin_err_i)   sts_nxt[ST_EBACK]  = 1'b1;
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_nxt;
    end

    // Outputs and software buffer port
    always_comb begin
        en_o         = en_q;
        caps_o       = {caps_q, 1'b1};
        faddr_o      = faddr_q;
        baddr_o      = baddr_q;
        op_o         = op_q;
        len_o        = len_q;
        irq          = sts_q[ST_DONE] && inten_q;
        sw_buf_we    = reg_we && win;
        sw_buf_idx   = roff;
        sw_buf_wdata = reg_wdata[7:0];
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        if (win) begin
            reg_rdata[7:0] = sw_buf_rdata;
        end else begin
            unique case (roff)
                BI_W'(OFF_CTRL):  reg_rdata[0] = en_q;
                BI_W'(OFF_CAPS):  reg_rdata[2:0] = {caps_q, 1'b1};
                BI_W'(OFF_FADDR): reg_rdata[FA_W-1:0] = faddr_q;
                BI_W'(OFF_BADDR): reg_rdata[BI_W-1:0] = baddr_q;
                BI_W'(OFF_CMD): begin
                    reg_rdata[1:0] = op_q;
                    reg_rdata[CMD_LEN_LSB +: LEN_W] = len_q;
                end
                BI_W'(OFF_STATUS): begin
                    reg_rdata[ST_W-1:0] = sts_q;
                    reg_rdata[ST_BUSY]  = busy_i;
                end
                BI_W'(OFF_INTEN): reg_rdata[0] = inten_q;
                default: ;
            endcase
        end
    end

    // R6: leaving busy always coincides with done being recorded
    a_r6_done_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_i) |-> sts_q[ST_DONE]);

    // R12: a one written to done clears it when no event sets it
    a_r12_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sts && reg_wdata[ST_DONE] && !fin_i && !rej_off_i && !rej_param_i
        |=> !sts_q[ST_DONE]);

endmodule

// File: rtl/flash_portal_ctrl.sv
// Flash portal command controller top level.
// Wires the register file, start validation, sequencer and local buffer.
// Assumes one register access per cycle and a backend that holds
// be_rdata / be_err valid only together with be_ack.
module flash_portal_ctrl
    import fpc_pkg::*;
#(
    parameter int FA_W      = 24,
    parameter int BUF_DEPTH = 64,
    parameter int DW        = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [$clog2(BUF_DEPTH):0]   reg_addr,
    input  logic [DW-1:0]                reg_wdata,
    output logic [DW-1:0]                reg_rdata,
    output logic                         irq,
    output logic                         be_req,
    output logic [1:0]                   be_op,
    output logic [FA_W-1:0]              be_addr,
    output logic [1:0]                   be_size,
    output logic [7:0]                   be_wdata,
    input  logic                         be_ack,
    input  logic [7:0]                   be_rdata,
    input  logic                         be_err
);

    localparam int BI_W  = $clog2(BUF_DEPTH);
    localparam int RA_W  = BI_W + 1;
    localparam int LEN_W = BI_W + 1;

    logic             en, go, busy, fin, fin_err;
    logic             launch, rej_busy, rej_off, rej_param;
    logic [2:0]       caps;
    logic [FA_W-1:0]  faddr;
    logic [BI_W-1:0]  baddr;
    op_e              op;
    logic [LEN_W-1:0] len;
    logic             sw_we, e_we;
    logic [BI_W-1:0]  sw_idx, e_idx;
    logic [7:0]       sw_wdata, sw_rdata, e_wdata, e_rdata;

    fpc_regs #(.FA_W(FA_W), .DW(DW), .BI_W(BI_W), .RA_W(RA_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .en_o(en), .caps_o(caps), .faddr_o(faddr), .baddr_o(baddr),
        .op_o(op), .len_o(len), .go_o(go), .busy_i(busy), .fin_i(fin),
        .fin_err_i(fin_err), .rej_busy_i(rej_busy), .rej_off_i(rej_off),
        .rej_param_i(rej_param), .sw_buf_we(sw_we), .sw_buf_idx(sw_idx),
        .sw_buf_wdata(sw_wdata), .sw_buf_rdata(sw_rdata)
    );

    fpc_check #(.LEN_W(LEN_W), .MAX_LEN(BUF_DEPTH)) u_check (
        .go_i(go), .busy_i(busy), .en_i(en), .op_i(op), .len_i(len),
        .caps_i(caps), .launch_o(launch), .rej_busy_o(rej_busy),
        .rej_off_o(rej_off), .rej_param_o(rej_param)
    );

    fpc_seq #(.FA_W(FA_W), .BI_W(BI_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .op_i(op), .len_i(len),
        .faddr_i(faddr), .baddr_i(baddr), .busy_o(busy), .fin_o(fin),
        .fin_err_o(fin_err), .be_req(be_req), .be_op(be_op),
        .be_addr(be_addr), .be_size(be_size), .be_wdata(be_wdata),
        .be_ack(be_ack), .be_rdata(be_rdata), .be_err(be_err),
        .buf_idx(e_idx), .buf_we(e_we), .buf_wdata(e_wdata),
        .buf_rdata(e_rdata)
    );

    fpc_buf #(.DEPTH(BUF_DEPTH), .BI_W(BI_W)) u_buf (
        .clk(clk), .e_we(e_we), .e_idx(e_idx), .e_wdata(e_wdata),
        .e_rdata(e_rdata), .s_we(sw_we), .s_idx(sw_idx),
        .s_wdata(sw_wdata), .s_rdata(sw_rdata)
    );

    // R7: the validator never launches into a running operation
    a_r7_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

    // R2: while disabled no backend request is raised by a new start
    a_r2_off_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !be_req && !en |=> !be_req);

endmodule

// File: tb/flash_portal_ctrl_test.sv
module flash_portal_ctrl_test;

    localparam int RA = 7;
    localparam int A_CTRL = 0, A_CAPS = 1, A_FADDR = 2, A_BADDR = 3;
    localparam int A_CMD = 4, A_START = 5, A_STATUS = 6, A_INTEN = 7, A_BUF = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [RA-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;
    logic          be_req;
    logic [1:0]    be_op;
    logic [23:0]   be_addr;
    logic [1:0]    be_size;
    logic [7:0]    be_wdata;
    logic          be_ack = 1'b0;
    logic [7:0]    be_rdata = '0;
    logic          be_err = 1'b0;

    int checks = 0;
    int fails = 0;
    int nreq = 0;
    int err_at = -1;
    int dly = 0;
    logic [23:0] lw_addr [128];
    logic [7:0]  lw_data [128];
    logic [1:0]  lw_op   [128];
    logic [1:0]  lw_size [128];
    logic [7:0]  sbuf    [64];

    flash_portal_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .be_req(be_req), .be_op(be_op), .be_addr(be_addr), .be_size(be_size),
        .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata), .be_err(be_err)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] fdat(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5C;
    endfunction

    // Backend model: random acknowledge delay, logs every beat
    initial begin
        forever begin
            @(negedge clk);
            if (be_ack) begin
                be_ack = 1'b0;
                be_err = 1'b0;
            end else if (be_req) begin
                if (dly > 0) dly--;
                else begin
                    if (nreq < 128) begin
                        lw_addr[nreq] = be_addr;
                        lw_data[nreq] = be_wdata;
                        lw_op[nreq]   = be_op;
                        lw_size[nreq] = be_size;
                    end
                    be_rdata = fdat(be_addr);
                    be_err   = (nreq == err_at);
                    nreq++;
                    be_ack   = 1'b1;
                    dly      = int'($urandom % 3);
                end
            end
        end
    end

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = RA'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = RA'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            rd(A_STATUS, s);
            if (s[0]) return;
            @(negedge clk);
        end
    endtask

    task automatic launch(input int op, input int len, input logic [23:0] fa, input int ba);
        wr(A_STATUS, 32'h1F);
        wr(A_FADDR, {8'h0, fa});
        wr(A_BADDR, ba);
        wr(A_CMD, (len << 8) | op);
        nreq = 0;
        wr(A_START, 1);
    endtask

    task automatic do_write(input int len, input logic [23:0] fa, input int ba, input string tag);
        int bad;
        logic [31:0] s;
        launch(1, len, fa, ba);
        wait_done();
        rd(A_STATUS, s);
        chk(tag, "write status", s, 32'h1);
        chk(tag, "write beats", nreq, len);
        bad = 0;
        for (int i = 0; i < len; i++)
            if (lw_addr[i] !== fa + 24'(i) || lw_data[i] !== sbuf[(ba + i) % 64] || lw_op[i] !== 2'd1) bad++;
        chk(tag, "write beat contents", bad, 0);
    endtask

    task automatic do_read(input int len, input logic [23:0] fa, input int ba, input string tag);
        int bad;
        logic [31:0] s;
        launch(0, len, fa, ba);
        wait_done();
        rd(A_STATUS, s);
        chk(tag, "read status", s, 32'h1);
        chk(tag, "read beats", nreq, len);
        for (int i = 0; i < len; i++) sbuf[(ba + i) % 64] = fdat(fa + 24'(i));
        bad = 0;
        for (int i = 0; i < 64; i++) begin
            rd(A_BUF + i, s);
            if (s[7:0] !== sbuf[i]) bad++;
        end
        chk(tag, "read buffer contents", bad, 0);
    endtask

    // Watchdog
    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s;
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STATUS, s); chk("R1", "status", s, 0);
        rd(A_CTRL, s);   chk("R1", "ctrl", s, 0);
        rd(A_CAPS, s);   chk("R1", "caps", s, 1);
        rd(A_INTEN, s);  chk("R1", "inten", s, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "be_req", be_req, 0);

        // R2 disabled start
        launch(1, 4, 24'h100, 0);
        rd(A_STATUS, s); chk("R2", "disabled status", s, 32'h5);
        repeat (4) @(negedge clk);
        chk("R2", "disabled requests", nreq, 0);
        chk("R13", "irq with inten clear", irq, 0);

        // R12 write-one-to-clear
        wr(A_STATUS, 32'h0); rd(A_STATUS, s); chk("R12", "write zero", s, 32'h5);
        wr(A_STATUS, 32'h4); rd(A_STATUS, s); chk("R12", "clear error only", s, 32'h1);
        wr(A_STATUS, 32'h1); rd(A_STATUS, s); chk("R12", "clear done", s, 32'h0);

        wr(A_CTRL, 1);
        for (int i = 0; i < 64; i++) begin
            sbuf[i] = 8'($urandom);
            wr(A_BUF + i, {24'h0, sbuf[i]});
        end

        // R8 / R9 directed corners: single byte, full buffer with wrap
        do_write(1, 24'h000010, 63, "R8");
        do_write(64, 24'hFFFFF0, 17, "R8");
        do_read(64, 24'h00ABC0, 5, "R9");
        do_read(1, 24'h123456, 63, "R9");

        // R3 illegal lengths
        launch(0, 0, 24'h0, 0);
        rd(A_STATUS, s); chk("R3", "length 0", s, 32'h3);
        launch(1, 65, 24'h0, 0);
        rd(A_STATUS, s); chk("R3", "length 65", s, 32'h3);
        repeat (4) @(negedge clk);
        chk("R3", "no request", nreq, 0);

        // R5 reserved type
        launch(3, 4, 24'h0, 0);
        rd(A_STATUS, s); chk("R5", "reserved type", s, 32'h3);

        // R4 erase size legality
        wr(A_CAPS, 0); rd(A_CAPS, s); chk("R4", "caps bit0 fixed", s, 1);
        launch(2, 1, 24'h2000, 0);
        rd(A_STATUS, s); chk("R4", "32K unsupported", s, 32'h3);
        launch(2, 3, 24'h2000, 0);
        rd(A_STATUS, s); chk("R4", "code 3", s, 32'h3);
        wr(A_CAPS, 3);
        launch(2, 2, 24'h2000, 0);
        rd(A_STATUS, s); chk("R4", "64K unsupported", s, 32'h3);
        launch(2, 5, 24'h2000, 0);
        rd(A_STATUS, s); chk("R4", "upper length bits", s, 32'h3);
        repeat (4) @(negedge clk);
        chk("R4", "no request", nreq, 0);

        // R10 accepted erases
        launch(2, 1, 24'h018000, 0);
        wait_done();
        rd(A_STATUS, s); chk("R10", "erase status", s, 32'h1);
        chk("R10", "erase beats", nreq, 1);
        chk("R10", "erase op", lw_op[0], 2);
        chk("R10", "erase size", lw_size[0], 1);
        chk("R10", "erase addr", lw_addr[0], 24'h018000);
        wr(A_CAPS, 0);
        launch(2, 0, 24'h004000, 0);
        wait_done();
        rd(A_STATUS, s); chk("R4", "4K always accepted", s, 32'h1);
        chk("R10", "4K size code", lw_size[0], 0);

        // R6 / R7 / R13 busy sequencing and interrupt
        wr(A_INTEN, 1);
        rd(A_STATUS, s); chk("R6", "idle before start", s[8], 0);
        launch(1, 64, 24'h000400, 0);
        rd(A_STATUS, s); chk("R6", "busy after start", s, 32'h100);
        chk("R13", "irq while busy", irq, 0);
        wr(A_START, 1);
        rd(A_STATUS, s); chk("R7", "busy error only", s, 32'h108);
        wait_done();
        rd(A_STATUS, s); chk("R6", "done with busy clear", s, 32'h9);
        chk("R7", "beats of first op", nreq, 64);
        chk("R13", "irq on done", irq, 1);
        wr(A_STATUS, 32'h1);
        chk("R13", "irq after clear", irq, 0);
        wr(A_INTEN, 0);

        // R11 backend error stops the operation
        err_at = 3;
        launch(1, 10, 24'h000800, 0);
        wait_done();
        rd(A_STATUS, s); chk("R11", "error status", s, 32'h11);
        chk("R11", "beats before stop", nreq, 4);
        err_at = -1;

        // Random mix of reads and writes
        for (int it = 0; it < 24; it++) begin
            int len, ba;
            logic [23:0] fa;
            len = 1 + int'($urandom % 64);
            ba  = int'($urandom % 64);
            fa  = 24'($urandom);
            if ($urandom % 2 == 0) do_write(len, fa, ba, "R8");
            else                   do_read(len, fa, ba, "R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule